// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Queue

This block takes 32-bit ARINC 429 words from a 16-bit host bus and sends them on a serial line. The host writes each word in two strobes. The first strobe holds the low half, and the second strobe adds the high half and commits the whole word to a 32-entry queue. While transmission is enabled, a sequencer takes words from the queue and sends each one as 32 return-to-zero bits. Each bit drives either a "high" line or a "low" line. The bit rate is the master clock divided by 10 or by 80.

Bit 32 of a word can be sent as loaded. It can also be replaced by a parity bit, computed so that the whole word has odd or even parity. The host sees the queue state through an empty flag, an active-low half-full flag and an active-low full flag. A ready flag stays high only while the queue is empty and the line is idle. A self-test input sends the line activity to a pair of loopback outputs instead of the line outputs. The analog driver and any register file live outside this block.

Top module: `arinc_tx_core`

## Requirements
- R1: A `load_lo` pulse captures `host_data` as word bits 15..0. A later `load_hi` pulse supplies bits 31..16 and commits the full 32-bit word to the queue.
- R2: A `load_hi` pulse with no `load_lo` pending since the last commit is ignored: nothing enters the queue. A second `load_hi` after a commit adds no word.
- R3: The queue holds 32 words and sends them in first-in first-out order. A commit while the queue is full is discarded. `empty` is 1 when the queue holds 0 words. `half_n` is 0 when it holds 16 or more words. `full_n` is 0 when it holds 32 words.
- R4: Each bit lasts 10 clocks when `slow_rate` is 0 and 80 clocks when it is 1. The rate is sampled when a word is taken from the queue.
- R5: Each bit is return-to-zero. For the first half of the bit time, `line_hi` is 1 for a one bit or `line_lo` is 1 for a zero bit. Both lines are 0 for the second half. The two lines are never 1 together.
- R6: Serial order: word bits 7,6,...,0 go out first (label, most significant bit first). Word bits 8,9,...,31 follow in that order.
- R7: When `par_en` is 0, word bit 31 is sent as loaded. When `par_en` is 1, bit 31 is replaced so that the 32 sent bits hold an odd number of ones (`par_even`=0) or an even number of ones (`par_even`=1). Both settings are sampled when the word is taken from the queue.
- R8: Between two words both lines stay 0. From the end of the last bit's pulse to the start of the next word's first pulse there are at least 4 bit times plus a half bit. When the next word is already queued, this null is exactly 4.5 bit times plus 1 clock.
- R9: A word is taken from the queue only while `tx_en` is 1. A word already being sent completes even if `tx_en` falls.
- R10: `tx_ready` goes to 0 in the cycle after a word is committed. It returns to 1 only when the queue is empty and the inter-word null after the last word has ended.
- R11: While `selftest` is 1, `line_hi` and `line_lo` are held at 0 and the bit pulses appear on `loop_hi` and `loop_lo`. While `selftest` is 0, `loop_hi` and `loop_lo` stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 16 | Host data half-word |
| load_lo | input | 1 | Strobe: capture low half |
| load_hi | input | 1 | Strobe: add high half and commit word |
| tx_en | input | 1 | Allows words to be taken from the queue |
| par_en | input | 1 | Replace bit 31 with parity |
| par_even | input | 1 | 0 = odd parity, 1 = even parity |
| slow_rate | input | 1 | 0 = clock/10, 1 = clock/80 |
| selftest | input | 1 | Route line activity to loopback outputs |
| line_hi | output | 1 | Line drive, one-bit pulse |
| line_lo | output | 1 | Line drive, zero-bit pulse |
| loop_hi | output | 1 | Loopback copy of high pulse |
| loop_lo | output | 1 | Loopback copy of low pulse |
| tx_ready | output | 1 | Queue empty and line idle |
| empty | output | 1 | Queue holds no words |
| half_n | output | 1 | Low at 16 or more queued words |
| full_n | output | 1 | Low at 32 queued words |

## Verification
The assertions assume the host never raises `load_lo` and `load_hi` in the same cycle. They also assume strobes are driven synchronously to the clock. Rate and parity inputs may change at any time, because the design samples them at word start. The stimulus changes `slow_rate`, `par_en` and `par_even` only after the queue has drained and the line is idle. This lets the bench tie each received word to one setting. All host inputs are driven on the falling clock edge, so the design always sees stable values at the rising edge.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned LABEL_W = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_BITS, SQ_GAP} seq_state_e;

  // Replace the top bit with parity over the rest when enabled.
  function automatic word_t apply_parity(input word_t w, input logic en, input logic even);
    word_t r;
    logic  rest_odd;
    r        = w;
    rest_odd = ^w[WORD_W-2:0];
    if (en) r[WORD_W-1] = even ? rest_odd : ~rest_odd;
    return r;
  endfunction

  // Arrange the word so that index 0 is the first bit on the wire.
  function automatic word_t to_wire_order(input word_t w);
    word_t r;
    for (int k = 0; k < WORD_W; k++) begin
      if (k < LABEL_W) r[k] = w[LABEL_W-1-k];
      else             r[k] = w[k];
    end
    return r;
  endfunction
endpackage

// File: rtl/arinc_tx_loader.sv
module arinc_tx_loader import arinc_tx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic [HALF_W-1:0] host_data,
  output logic              push,
  output word_t             push_word
);
  logic [HALF_W-1:0] lo_q, lo_d;
  logic              pend_q, pend_d;

  always_comb begin
    push      = load_hi && pend_q;
    push_word = {host_data, lo_q};
    lo_d      = load_lo ? host_data : lo_q;
    if (load_lo)      pend_d = 1'b1;
    else if (load_hi) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      pend_q <= pend_d;
    end
  end

  // R2: a high strobe always consumes the pending low half
  p_hi_consumes_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && !load_lo) |=> !pend_q);
  // R1: a commit is only possible after a low strobe was seen
  p_commit_after_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(load_lo));
endmodule

// File: rtl/arinc_tx_fifo.sv
module arinc_tx_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_word,
  input  logic                       pop,
  output logic [W-1:0]               head_word,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
    wr_d    = wr_q;
    rd_d    = rd_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_word;
  end

  assign head_word = mem[rd_q];
  assign count     = cnt_q;

  // R3: a commit into a full queue without a pop leaves it full, no growth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push && !pop) |=> (cnt_q == CW'(DEPTH)));
  // R3: popping an empty queue does not wrap the count
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/arinc_tx_bit_timer.sv
module arinc_tx_bit_timer #(
  parameter int unsigned DIV_FAST = 10,
  parameter int unsigned DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic bit_end,
  output logic first_half
);
  localparam int unsigned DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int unsigned PH_W    = $clog2(DIV_MAX);

  logic [PH_W-1:0] phase_q, phase_d, div_last, div_half;

  always_comb begin
    div_last   = slow ? PH_W'(DIV_SLOW - 1) : PH_W'(DIV_FAST - 1);
    div_half   = slow ? PH_W'(DIV_SLOW / 2) : PH_W'(DIV_FAST / 2);
    bit_end    = run && (phase_q == div_last);
    first_half = phase_q < div_half;
    if (!run || bit_end) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R4: the phase never passes the last clock of the selected bit time
  p_phase_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= div_last);
  // R4: an idle timer rests at phase zero so every word starts on a bit boundary
  p_idle_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_q == '0));
endmodule

// File: rtl/arinc_tx_sequencer.sv
module arinc_tx_sequencer import arinc_tx_pkg::*; #(
  parameter int unsigned GAP_BITS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_en,
  input  logic  fifo_empty,
  input  word_t fifo_word,
  input  logic  par_en,
  input  logic  par_even,
  input  logic  slow_rate,
  input  logic  bit_end,
  input  logic  first_half,
  output logic  pop,
  output logic  run,
  output logic  slow_q,
  output logic  drive_hi,
  output logic  drive_lo
);
  localparam int unsigned CNT_TOP = (WORD_W > GAP_BITS) ? WORD_W : GAP_BITS;
  localparam int unsigned CNT_W   = $clog2(CNT_TOP);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  word_t            sh_q, sh_d;
  logic             slow_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    slow_d  = slow_q;
    pop     = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (tx_en && !fifo_empty) begin
          pop     = 1'b1;
          sh_d    = to_wire_order(apply_parity(fifo_word, par_en, par_even));
          slow_d  = slow_rate;
          cnt_d   = '0;
          state_d = SQ_BITS;
        end
      end
      SQ_BITS: begin
        if (bit_end) begin
          sh_d = sh_q >> 1;
          if (cnt_q == CNT_W'(WORD_W - 1)) begin
            cnt_d   = '0;
            state_d = SQ_GAP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SQ_GAP: begin
        if (bit_end) begin
          if (cnt_q == CNT_W'(GAP_BITS - 1)) begin
            cnt_d   = '0;
            state_d = SQ_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      slow_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      slow_q  <= slow_d;
    end
  end

  always_comb begin
    run      = (state_q != SQ_IDLE);
    drive_hi = (state_q == SQ_BITS) && first_half && sh_q[0];
    drive_lo = (state_q == SQ_BITS) && first_half && !sh_q[0];
  end

  // R5: the two drive levels are mutually exclusive
  p_rz_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_hi && drive_lo));
  // R5: no pulse in the second half of a bit
  p_rz_second_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !first_half |-> !(drive_hi || drive_lo));
  // R9: a word only starts when transmission was enabled
  p_start_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(tx_en));
  // R4: the rate in use is frozen for the whole word and its null
  p_rate_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(slow_q));
  // R8: the inter-word null keeps both drives low
  p_null_in_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_GAP) |-> !(drive_hi || drive_lo));
endmodule

// File: rtl/arinc_tx_core.sv
module arinc_tx_core import arinc_tx_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned DIV_FAST   = 10,
  parameter int unsigned DIV_SLOW   = 80,
  parameter int unsigned GAP_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] host_data,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              slow_rate,
  input  logic              selftest,
  output logic              line_hi,
  output logic              line_lo,
  output logic              loop_hi,
  output logic              loop_lo,
  output logic              tx_ready,
  output logic              empty,
  output logic              half_n,
  output logic              full_n
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic             push, pop, run, slow_q, bit_end, first_half;
  logic             drive_hi, drive_lo, fifo_empty;
  word_t            push_word, head_word;
  logic [CNT_W-1:0] count;

  arinc_tx_loader u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_lo   (load_lo),
    .load_hi   (load_hi),
    .host_data (host_data),
    .push      (push),
    .push_word (push_word)
  );

  arinc_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word (push_word),
    .pop       (pop),
    .head_word (head_word),
    .count     (count)
  );

  arinc_tx_bit_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .slow       (slow_q),
    .bit_end    (bit_end),
    .first_half (first_half)
  );

  arinc_tx_sequencer #(.GAP_BITS(GAP_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .fifo_empty (fifo_empty),
    .fifo_word  (head_word),
    .par_en     (par_en),
    .par_even   (par_even),
    .slow_rate  (slow_rate),
    .bit_end    (bit_end),
    .first_half (first_half),
    .pop        (pop),
    .run        (run),
    .slow_q     (slow_q),
    .drive_hi   (drive_hi),
    .drive_lo   (drive_lo)
  );

  always_comb begin
    fifo_empty = (count == '0);
    empty      = fifo_empty;
    half_n     = !(count >= CNT_W'(FIFO_DEPTH / 2));
    full_n     = !(count == CNT_W'(FIFO_DEPTH));
    tx_ready   = fifo_empty && !run;
    line_hi    = drive_hi && !selftest;
    line_lo    = drive_lo && !selftest;
    loop_hi    = drive_hi && selftest;
    loop_lo    = drive_lo && selftest;
  end

  // R10: an accepted commit drops the ready flag in the next cycle
  p_ready_low_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full_n) |=> !tx_ready);
  // R11: self test silences the line outputs
  p_selftest_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    selftest |-> !(line_hi || line_lo));
  // R3: a full queue is never reported empty, and full implies half full
  p_flag_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (!half_n && !empty));
endmodule

// File: tb/arinc_tx_core_tb.sv
`timescale 1ns/1ps
module arinc_tx_core_tb;
  logic        clk, rst_n;
  logic [15:0] host_data;
  logic        load_lo, load_hi, tx_en, par_en, par_even, slow_rate, selftest;
  logic        line_hi, line_lo, loop_hi, loop_lo, tx_ready, empty, half_n, full_n;

  arinc_tx_core u_dut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .load_lo(load_lo), .load_hi(load_hi),
    .tx_en(tx_en), .par_en(par_en), .par_even(par_even), .slow_rate(slow_rate),
    .selftest(selftest), .line_hi(line_hi), .line_lo(line_lo), .loop_hi(loop_hi),
    .loop_lo(loop_lo), .tx_ready(tx_ready), .empty(empty), .half_n(half_n), .full_n(full_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int unsigned cyc_all = 0;

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all == 150000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc_all);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- line monitor (receiver model) ----------------
  logic [31:0] rx_word [0:127];
  int rx_wmin [0:127];
  int rx_wmax [0:127];
  int rx_pmin [0:127];
  int rx_pmax [0:127];
  int rx_gap  [0:127];
  int rx_n = 0;
  int nbits = 0, null_run = 0, run_w = 0, mcyc = 0, last_start = 0;
  int c_wmin, c_wmax, c_pmin, c_pmax, c_gap;
  logic [31:0] c_bits;
  logic prev_s = 1'b0;
  int both_err = 0, viol_line = 0, viol_loop = 0;

  always @(negedge clk) begin
    logic h, l, s;
    logic [31:0] w;
    if (rst_n) begin
      h = selftest ? loop_hi : line_hi;
      l = selftest ? loop_lo : line_lo;
      s = h | l;
      if (h && l) both_err++;
      if (selftest && (line_hi || line_lo)) viol_line++;
      if (!selftest && (loop_hi || loop_lo)) viol_loop++;
      if (s && !prev_s) begin
        if (nbits == 0) begin
          c_gap = null_run; c_wmin = 9999; c_wmax = 0; c_pmin = 9999; c_pmax = 0;
        end else begin
          if (mcyc - last_start < c_pmin) c_pmin = mcyc - last_start;
          if (mcyc - last_start > c_pmax) c_pmax = mcyc - last_start;
        end
        last_start = mcyc;
        c_bits[nbits] = h;
        run_w = 1;
      end else if (s) begin
        run_w++;
      end
      if (!s && prev_s) begin
        if (run_w < c_wmin) c_wmin = run_w;
        if (run_w > c_wmax) c_wmax = run_w;
        nbits++;
        if (nbits == 32) begin
          for (int k = 0; k < 32; k++) begin
            if (k < 8) w[7-k] = c_bits[k];
            else       w[k]   = c_bits[k];
          end
          rx_word[rx_n] = w;  rx_wmin[rx_n] = c_wmin; rx_wmax[rx_n] = c_wmax;
          rx_pmin[rx_n] = c_pmin; rx_pmax[rx_n] = c_pmax; rx_gap[rx_n] = c_gap;
          rx_n++;
          nbits = 0;
        end
      end
      null_run = s ? 0 : null_run + 1;
      prev_s = s;
      mcyc++;
    end
  end

  // ---------------- expected model ----------------
  logic [31:0] exp_w [0:127];
  int exp_n = 0;

  function automatic logic [31:0] par_fix(input logic [31:0] w, input logic pe, input logic ev);
    logic [31:0] r;
    int ones;
    r = w;
    ones = $countones(w[30:0]);
    if (pe) r[31] = ev ? (ones % 2 == 1) : (ones % 2 == 0);
    return r;
  endfunction

  function automatic logic [31:0] gen(input int i);
    logic [31:0] a;
    a = 32'h9E3779B9 * (i + 1);
    return a ^ (32'(i) << 11) ^ 32'h5A5A00C3;
  endfunction

  task automatic load_word(input logic [31:0] w, input bit expect_kept);
    host_data = w[15:0]; load_lo = 1'b1;
    @(negedge clk);
    load_lo = 1'b0; host_data = w[31:16]; load_hi = 1'b1;
    @(negedge clk);
    load_hi = 1'b0; host_data = '0;
    if (expect_kept) begin
      exp_w[exp_n] = par_fix(w, par_en, par_even);
      exp_n++;
    end
  endtask

  task automatic wait_rx(input int n);
    while (rx_n < n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic verify_batch(input int first, input int cnt, input int div);
    for (int i = first; i < first + cnt; i++) begin
      chk(rx_word[i] == exp_w[i], "R6/R1 received word", rx_word[i], exp_w[i]);
      chk(rx_wmin[i] == div / 2 && rx_wmax[i] == div / 2, "R5 pulse width", rx_wmax[i], div / 2);
      chk(rx_pmin[i] == div && rx_pmax[i] == div, "R4 bit period", rx_pmin[i], div);
      if (i > first)
        chk(rx_gap[i] == div / 2 + 4 * div + 1, "R8 inter-word null", rx_gap[i], div / 2 + 4 * div + 1);
    end
  endtask

  initial begin
    int base;
    rst_n = 1'b0; host_data = '0; load_lo = 0; load_hi = 0; tx_en = 0;
    par_en = 0; par_even = 0; slow_rate = 0; selftest = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // Reset state (R3, R10)
    chk(empty == 1'b1, "R3 empty after reset", empty, 1);
    chk(half_n == 1'b1 && full_n == 1'b1, "R3 flags after reset", {half_n, full_n}, 2'b11);
    chk(tx_ready == 1'b1, "R10 ready after reset", tx_ready, 1);
    chk(!line_hi && !line_lo, "R5 lines idle after reset", {line_hi, line_lo}, 0);

    // R2: lone high strobe ignored
    host_data = 16'hBEEF; load_hi = 1'b1; @(negedge clk); load_hi = 1'b0;
    idle(2);
    chk(empty == 1'b1, "R2 lone load_hi ignored (empty)", empty, 1);
    chk(tx_ready == 1'b1, "R2 lone load_hi ignored (ready)", tx_ready, 1);

    // R1/R9/R10: load three words while disabled
    for (int i = 0; i < 3; i++) load_word(gen(i), 1);
    chk(tx_ready == 1'b0, "R10 ready low after load", tx_ready, 0);
    chk(empty == 1'b0, "R3 not empty after load", empty, 0);
    idle(500);
    chk(rx_n == 0, "R9 nothing sent while disabled", rx_n, 0);
    tx_en = 1'b1;
    wait_rx(3);
    verify_batch(0, 3, 10);
    chk(tx_ready == 1'b0, "R10 ready low during trailing null", tx_ready, 0);
    idle(60);
    chk(tx_ready == 1'b1, "R10 ready back high after drain", tx_ready, 1);

    // R2: extra high strobe after a commit adds nothing
    tx_en = 1'b0;
    base = rx_n;
    load_word(32'h0000_00FF, 1);
    host_data = 16'h1234; load_hi = 1'b1; @(negedge clk); load_hi = 1'b0;
    tx_en = 1'b1;
    wait_rx(base + 1);
    idle(600);
    chk(rx_n == base + 1, "R2 second load_hi adds no word", rx_n, base + 1);
    verify_batch(base, 1, 10);

    // R7: odd then even parity
    for (int m = 0; m < 3; m++) begin
      tx_en = 1'b0;
      par_en = (m != 0); par_even = (m == 2);
      base = rx_n;
      for (int i = 0; i < 4; i++) load_word(gen(40 + 4 * m + i) ^ (32'(i) << 31), 1);
      tx_en = 1'b1;
      wait_rx(base + 4);
      idle(60);
      verify_batch(base, 4, 10);
      for (int i = base; i < base + 4; i++)
        if (m != 0)
          chk(($countones(rx_word[i]) % 2) == (m == 2 ? 0 : 1), "R7 parity of sent word",
              $countones(rx_word[i]), m == 2 ? 0 : 1);
        else
          chk(rx_word[i][31] == exp_w[i][31], "R7 bit 32 sent as data", rx_word[i][31], exp_w[i][31]);
    end
    par_en = 0; par_even = 0;

    // R4: slow rate
    tx_en = 1'b0; slow_rate = 1'b1;
    base = rx_n;
    load_word(32'hA5C3_0F81, 1);
    load_word(32'h0123_4567, 1);
    tx_en = 1'b1;
    wait_rx(base + 2);
    verify_batch(base, 2, 80);
    idle(420);
    slow_rate = 1'b0;

    // R3: fill queue, flags, overflow discard
    tx_en = 1'b0;
    base = rx_n;
    for (int i = 0; i < 15; i++) load_word(gen(100 + i), 1);
    chk(half_n == 1'b1, "R3 half_n high at 15 words", half_n, 1);
    load_word(gen(115), 1);
    chk(half_n == 1'b0, "R3 half_n low at 16 words", half_n, 0);
    chk(full_n == 1'b1, "R3 full_n high at 16 words", full_n, 1);
    for (int i = 16; i < 31; i++) load_word(gen(100 + i), 1);
    chk(full_n == 1'b1, "R3 full_n high at 31 words", full_n, 1);
    load_word(gen(131), 1);
    chk(full_n == 1'b0, "R3 full_n low at 32 words", full_n, 0);
    load_word(32'hDEAD_DEAD, 0);
    chk(full_n == 1'b0 && empty == 1'b0, "R3 still full after discarded write", full_n, 0);
    tx_en = 1'b1;
    wait_rx(base + 32);
    verify_batch(base, 32, 10);
    idle(1000);
    chk(rx_n == base + 32, "R3 overflow word never sent", rx_n, base + 32);
    chk(empty == 1'b1 && tx_ready == 1'b1, "R3 empty after drain", {empty, tx_ready}, 2'b11);

    // R9: disable mid-word, word completes, next waits
    tx_en = 1'b0;
    base = rx_n;
    load_word(gen(200), 1);
    load_word(gen(201), 1);
    tx_en = 1'b1;
    while (nbits < 3) @(negedge clk);
    tx_en = 1'b0;
    wait_rx(base + 1);
    idle(800);
    chk(rx_n == base + 1, "R9 word in flight completes, next held", rx_n, base + 1);
    tx_en = 1'b1;
    wait_rx(base + 2);
    chk(rx_word[base] == exp_w[base] && rx_word[base+1] == exp_w[base+1],
        "R9 both words intact", rx_word[base + 1], exp_w[base + 1]);
    idle(60);

    // R11: self test loopback
    selftest = 1'b1;
    base = rx_n;
    load_word(32'h8000_0001, 1);
    load_word(32'h7FFF_FFFE, 1);
    wait_rx(base + 2);
    verify_batch(base, 2, 10);
    idle(60);
    selftest = 1'b0;
    chk(viol_line == 0, "R11 line quiet during self test", viol_line, 0);
    chk(viol_loop == 0, "R11 loopback quiet outside self test", viol_loop, 0);
    chk(both_err == 0, "R5 lines never high together", both_err, 0);
    chk(rx_n == exp_n, "R3 total words sent", rx_n, exp_n);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule